// File: doc/BRIEF.md
# Serial Transmitter with Break Generation

This block is an asynchronous serial transmitter with a one-byte holding buffer in front of a shift register. It sends ordinary data frames (start bit, eight data bits least significant first, stop bit). On request it sends instead a long break character of the kind a bus master places at the head of a message. Bit timing comes from an external baud tick: every bit lasts from one tick to the next, and a frame starts only on a tick.

A break is armed by pulsing `brk_set_i`, which sets the internal send-break flag seen on `brk_o`. The next byte that moves from the buffer into the shifter while the flag is set becomes a break frame: a start bit, twelve zero bits and a stop bit. The byte's value is discarded. The flag clears itself at the tick that ends the break's stop bit. A byte written during the break, usually the sync value 0x55, waits in the buffer. It goes out as a normal frame directly behind the break.

Top module: `uart_brk_tx`

## Requirements
- R1: While `rst_ni` is low and after its release, `txd_o`=1, `buf_empty_o`=1, `shift_idle_o`=1 and `brk_o`=0.
- R2: A normal frame drives 0 for the start bit, then data bits 0..7 in that order, then 1 for the stop bit. Each bit holds from one asserted `baud_tick_i` cycle to the next, frames start only at a tick, and the line is 1 while the shifter is idle.
- R3: A break frame drives 0 for 13 bit periods (start plus twelve zeros) and then 1 for one stop period, 14 periods in all. The written byte value has no effect on the line.
- R4: The send-break flag is sampled only when a byte moves into the shifter. Setting it during a normal frame leaves that frame unchanged, and the flag stays set until a break frame completes.
- R5: A pulse on `brk_set_i` sets `brk_o` on the next cycle. `brk_o` clears at the tick that ends a break frame's stop bit, and at no other time.
- R6: A byte written while a break is shifting is sent as a normal frame whose start bit begins at the tick that ends the break's stop bit, with no idle period between them.
- R7: `buf_empty_o` goes low on the cycle after an accepted write. It goes high on the cycle after the byte moves into the shifter.
- R8: `shift_idle_o` goes low on the cycle after a byte moves into the shifter. It stays low until the tick that ends a stop bit with no byte queued, for normal frames and for break frames.
- R9: A write while `buf_empty_o` is 0 is ignored and produces no frame.
- R10: With `tx_en_i` low, the line is 1, any frame in progress and any queued byte are dropped by the next cycle, and writes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable |
| brk_set_i | input | 1 | One-cycle pulse that arms a break for the next loaded byte |
| wr_i | input | 1 | Write strobe for the holding buffer |
| wr_data_i | input | 8 | Byte to send |
| baud_tick_i | input | 1 | One-cycle pulse marking each bit boundary |
| txd_o | output | 1 | Serial line, idles high |
| buf_empty_o | output | 1 | Holding buffer can take a byte |
| shift_idle_o | output | 1 | No frame is being shifted |
| brk_o | output | 1 | Send-break flag, cleared by hardware |

## Verification
Normal frames are sent with 0xA5, 0x01 and 0x80. These separate bit order from stop-bit and start-bit handling, and the per-frame count of busy ticks checks the frame length. A break armed before a dummy write of 0x3C is followed by a queued 0x55, and a second break uses data 0xFF. Together they show that the data is discarded, that the flag clears only after the stop bit, and that the sync frame follows with no gap. Other patterns cover a flag raised during a normal frame, a third write into a full buffer, and an enable drop in mid-frame. These separate load-time sampling, overflow rejection and abort behaviour.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_BODY  = 2'd2,
    PH_STOP  = 2'd3
  } tx_phase_e;

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/tx_hold_buf.sv
module tx_hold_buf #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              take_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (flush_i) begin
      valid_o <= 1'b0;
    end else if (take_i) begin
      valid_o <= 1'b0;
    end else if (wr_i && !valid_o) begin
      valid_o <= 1'b1;
      data_o  <= wr_data_i;
    end
  end
endmodule

// File: rtl/tx_brk_ctrl.sv
module tx_brk_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic done_i,
  output logic pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_o <= 1'b0;
    else if (set_i)  pend_o <= 1'b1;
    else if (done_i) pend_o <= 1'b0;
  end
endmodule

// File: rtl/tx_shift_unit.sv
module tx_shift_unit
  import uart_brk_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned BRK_ZEROS = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              hold_valid_i,
  input  logic [DATA_W-1:0] hold_data_i,
  input  logic              brk_pend_i,
  output logic              take_o,
  output logic              brk_done_o,
  output logic              busy_o,
  output logic              txd_o
);
  localparam int unsigned MAX_BODY = max_u(DATA_W, BRK_ZEROS);
  localparam int unsigned CNT_W    = $clog2(MAX_BODY + 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] BRK_LAST  = CNT_W'(BRK_ZEROS - 1);

  tx_phase_e         phase_q;
  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              brk_mode_q;
  logic              can_load;
  logic              brk_eff;

  assign can_load   = (phase_q == PH_IDLE) || (phase_q == PH_STOP);
  assign take_o     = en_i && tick_i && hold_valid_i && can_load;
  assign brk_done_o = en_i && tick_i && (phase_q == PH_STOP) && brk_mode_q;
  // a break finishing on this tick must not turn the queued byte into a break
  assign brk_eff    = brk_pend_i && !brk_done_o;
  assign busy_o     = (phase_q != PH_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      sh_q       <= '0;
      cnt_q      <= '0;
      brk_mode_q <= 1'b0;
    end else if (!en_i) begin
      phase_q    <= PH_IDLE;
      brk_mode_q <= 1'b0;
    end else if (tick_i) begin
      if (take_o) begin
        phase_q    <= PH_START;
        brk_mode_q <= brk_eff;
        sh_q       <= brk_eff ? '0 : hold_data_i;
      end else begin
        unique case (phase_q)
          PH_START: begin
            phase_q <= PH_BODY;
            cnt_q   <= brk_mode_q ? BRK_LAST : DATA_LAST;
          end
          PH_BODY: begin
            if (cnt_q == '0) begin
              phase_q <= PH_STOP;
            end else begin
              cnt_q <= cnt_q - 1'b1;
              sh_q  <= sh_q >> 1;
            end
          end
          PH_STOP: phase_q <= PH_IDLE;
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    unique case (phase_q)
      PH_START: txd_o = 1'b0;
      PH_BODY:  txd_o = sh_q[0];
      default:  txd_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned BRK_ZEROS = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              brk_set_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              baud_tick_i,
  output logic              txd_o,
  output logic              buf_empty_o,
  output logic              shift_idle_o,
  output logic              brk_o
);
  logic              hold_valid;
  logic [DATA_W-1:0] hold_data;
  logic              take;
  logic              brk_done;
  logic              busy;
  logic              wr_ok;

  assign wr_ok = wr_i && tx_en_i;

  tx_hold_buf #(.DATA_W(DATA_W)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (!tx_en_i),
    .wr_i      (wr_ok),
    .wr_data_i (wr_data_i),
    .take_i    (take),
    .valid_o   (hold_valid),
    .data_o    (hold_data)
  );

  tx_brk_ctrl u_brk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (brk_set_i),
    .done_i (brk_done),
    .pend_o (brk_o)
  );

  tx_shift_unit #(.DATA_W(DATA_W), .BRK_ZEROS(BRK_ZEROS)) u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (tx_en_i),
    .tick_i       (baud_tick_i),
    .hold_valid_i (hold_valid),
    .hold_data_i  (hold_data),
    .brk_pend_i   (brk_o),
    .take_o       (take),
    .brk_done_o   (brk_done),
    .busy_o       (busy),
    .txd_o        (txd_o)
  );

  assign buf_empty_o  = !hold_valid;
  assign shift_idle_o = !busy;
endmodule

// File: rtl/uart_brk_tx_chk.sv
module uart_brk_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_en_i,
  input logic baud_tick_i,
  input logic txd_o,
  input logic buf_empty_o,
  input logic shift_idle_o,
  input logic brk_o
);
  assert_idle_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_idle_o |-> txd_o);

  assert_line_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(baud_tick_i) && $past(tx_en_i)) |-> $stable(txd_o));

  assert_start_on_tick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(shift_idle_o) |-> $past(baud_tick_i));

  assert_empty_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(buf_empty_o) |-> ($past(baud_tick_i) || !$past(tx_en_i)));

  assert_brk_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(brk_o) |-> $past(baud_tick_i));

  assert_off_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> (txd_o && shift_idle_o && buf_empty_o));
endmodule

bind uart_brk_tx uart_brk_tx_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tx_en_i      (tx_en_i),
  .baud_tick_i  (baud_tick_i),
  .txd_o        (txd_o),
  .buf_empty_o  (buf_empty_o),
  .shift_idle_o (shift_idle_o),
  .brk_o        (brk_o)
);

// File: tb/uart_brk_tx_tb_top.sv
module uart_brk_tx_tb_top;
  localparam int TICK_DIV = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tx_en_i = 1'b1;
  logic       brk_set_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic       baud_tick_i = 1'b0;
  logic       txd_o, buf_empty_o, shift_idle_o, brk_o;

  int n_chk = 0;
  int n_fail = 0;
  bit mon_skip = 1'b0;
  int busy_run = 0;
  int last_run = 0;
  int tick_cnt = 0;
  bit exp_q[$];
  string tag_q[$];

  always #4 clk_i = ~clk_i;

  uart_brk_tx dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tx_en_i(tx_en_i), .brk_set_i(brk_set_i),
    .wr_i(wr_i), .wr_data_i(wr_data_i), .baud_tick_i(baud_tick_i),
    .txd_o(txd_o), .buf_empty_o(buf_empty_o), .shift_idle_o(shift_idle_o),
    .brk_o(brk_o)
  );

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic push_frame(bit brk, logic [7:0] d, string tag);
    exp_q.push_back(1'b0); tag_q.push_back(tag);
    if (brk) begin
      for (int i = 0; i < 12; i++) begin exp_q.push_back(1'b0); tag_q.push_back(tag); end
    end else begin
      for (int i = 0; i < 8; i++) begin exp_q.push_back(d[i]); tag_q.push_back(tag); end
    end
    exp_q.push_back(1'b1); tag_q.push_back(tag);
  endtask

  // tick generator and line monitor
  always @(negedge clk_i) begin
    bit seen;
    seen = baud_tick_i;
    if (seen && rst_ni) begin
      if (!shift_idle_o) begin
        busy_run++;
        if (!mon_skip) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R9", "unexpected frame bit", int'(txd_o), -1);
          end else begin
            bit e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(txd_o == e, t, "line bit", int'(txd_o), int'(e));
          end
        end
      end else begin
        if (busy_run != 0) begin last_run = busy_run; busy_run = 0; end
        chk(txd_o == 1'b1, "R2", "idle line", int'(txd_o), 1);
      end
    end
    tick_cnt = (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
    baud_tick_i = (tick_cnt == 0);
  end

  task automatic wr_byte(logic [7:0] d);
    @(negedge clk_i); wr_i = 1'b1; wr_data_i = d;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic pulse_brk();
    @(negedge clk_i); brk_set_i = 1'b1;
    @(negedge clk_i); brk_set_i = 1'b0;
  endtask

  task automatic wait_busy();
    while (shift_idle_o) @(negedge clk_i);
  endtask

  task automatic wait_done();
    while (!(shift_idle_o && buf_empty_o)) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
  endtask

  task automatic run_test();
    // R1 reset
    repeat (3) @(negedge clk_i);
    chk(txd_o == 1'b1, "R1", "txd in reset", int'(txd_o), 1);
    chk(buf_empty_o == 1'b1, "R1", "buf_empty in reset", int'(buf_empty_o), 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(txd_o == 1'b1, "R1", "txd after reset", int'(txd_o), 1);
    chk(buf_empty_o == 1'b1, "R1", "buf_empty after reset", int'(buf_empty_o), 1);
    chk(shift_idle_o == 1'b1, "R1", "shift_idle after reset", int'(shift_idle_o), 1);
    chk(brk_o == 1'b0, "R1", "brk after reset", int'(brk_o), 0);

    // R2 normal frames, R7/R8 flags
    push_frame(1'b0, 8'hA5, "R2");
    wr_byte(8'hA5);
    chk(buf_empty_o == 1'b0, "R7", "buf_empty after write", int'(buf_empty_o), 0);
    wait_busy();
    chk(buf_empty_o == 1'b1, "R7", "buf_empty after load", int'(buf_empty_o), 1);
    wait_done();
    chk(last_run == 10, "R8", "normal frame busy ticks", last_run, 10);
    push_frame(1'b0, 8'h01, "R2"); wr_byte(8'h01); wait_done();
    push_frame(1'b0, 8'h80, "R2"); wr_byte(8'h80); wait_done();

    // R3/R5/R6 break header followed by sync
    pulse_brk();
    chk(brk_o == 1'b1, "R5", "brk after set pulse", int'(brk_o), 1);
    push_frame(1'b1, 8'h3C, "R3");
    push_frame(1'b0, 8'h55, "R6");
    wr_byte(8'h3C);
    wait_busy();
    wr_byte(8'h55);
    chk(brk_o == 1'b1, "R5", "brk held during break", int'(brk_o), 1);
    while (!buf_empty_o) @(negedge clk_i);
    chk(shift_idle_o == 1'b0, "R6", "sync loaded back to back", int'(shift_idle_o), 0);
    chk(brk_o == 1'b0, "R5", "brk cleared after break stop", int'(brk_o), 0);
    wait_done();
    chk(last_run == 24, "R6", "break plus sync busy ticks", last_run, 24);

    // R4 flag raised mid normal frame
    push_frame(1'b0, 8'h0F, "R4");
    wr_byte(8'h0F);
    wait_busy();
    pulse_brk();
    wait_done();
    chk(brk_o == 1'b1, "R4", "brk kept after normal frame", int'(brk_o), 1);
    push_frame(1'b1, 8'hFF, "R3");
    wr_byte(8'hFF);
    wait_done();
    chk(last_run == 14, "R3", "break frame busy ticks", last_run, 14);
    chk(brk_o == 1'b0, "R5", "brk cleared after break", int'(brk_o), 0);

    // R9 write into full buffer
    push_frame(1'b0, 8'h11, "R9");
    push_frame(1'b0, 8'h22, "R9");
    wr_byte(8'h11);
    wait_busy();
    wr_byte(8'h22);
    chk(buf_empty_o == 1'b0, "R9", "buffer full", int'(buf_empty_o), 0);
    wr_byte(8'h33);
    wait_done();
    chk(last_run == 20, "R9", "two frames only", last_run, 20);
    chk(exp_q.size() == 0, "R9", "expected bits left", exp_q.size(), 0);

    // R10 enable drop mid frame and writes while disabled
    mon_skip = 1'b1;
    wr_byte(8'h00);
    wait_busy();
    repeat (6) @(negedge clk_i);
    tx_en_i = 1'b0;
    @(negedge clk_i);
    chk(txd_o == 1'b1, "R10", "line high when disabled", int'(txd_o), 1);
    chk(shift_idle_o == 1'b1, "R10", "frame dropped", int'(shift_idle_o), 1);
    wr_byte(8'h5A);
    chk(buf_empty_o == 1'b1, "R10", "write ignored when disabled", int'(buf_empty_o), 1);
    tx_en_i = 1'b1;
    repeat (3 * TICK_DIV) @(negedge clk_i);
    chk(shift_idle_o == 1'b1, "R10", "no frame after enable", int'(shift_idle_o), 1);
    mon_skip = 1'b0;
    chk(exp_q.size() == 0, "R2", "scoreboard drained", exp_q.size(), 0);
  endtask

  initial begin
    fork
      run_test();
      begin
        repeat (150000) @(posedge clk_i);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule